// File: doc/BRIEF.md
# Bandwidth-Throttled Memory Target

This block is a single-ported memory slave with a small word store behind it. It takes one request per cycle at most. Every accepted request is serviced at once, and any reply is released a fixed number of cycles later through an internal timestamped reply queue. Short-term throughput is capped per packet. Each accepted read or write holds the target busy for a window whose length is the payload byte count scaled by a cycles-per-byte ratio, rounded up to whole cycles. Reads and writes share this window, because they use the same bidirectional data path.

A request that arrives during the window is refused, and the target records that it owes the requester a retry. When the window closes, the target spends one cycle emitting a retry strobe and then opens again. The requester uses that strobe to send the refused request again. Commands other than reads and writes never open a window, and neither does a request whose computed window is zero cycles long.

The throttle is a four-state machine. In IDLE it accepts requests. BUSY is an open window with no retry owed. BUSY_OWED is an open window with a retry owed. RETRY is the one strobe cycle. The transitions are:
- START: IDLE to BUSY, when a read or write with a non-zero window is accepted.
- REFUSE: BUSY to BUSY_OWED, when a request arrives during the window.
- EXPIRE: BUSY to IDLE, when the window ends with no retry owed.
- EXPIRE_OWED: BUSY_OWED to RETRY, or BUSY to RETRY directly when a refusal falls in the last window cycle.
- REOPEN: RETRY to IDLE.

Top module: `bwmem_target`

## Requirements
- R1: After reset, a valid request is accepted in its first cycle, and no reply and no retry strobe are shown until one is due.
- R2: An accepted read, write or posted write of S bytes refuses requests in the next ceil(S*CPB_NUM/CPB_DEN) cycles. With the defaults (8 bytes per cycle), a 64-byte request blocks 8 cycles and a 17-byte request blocks 3.
- R3: Reads and writes share one window: a read following a write is refused while the write's window is open, and the reverse holds too.
- R4: Command 2'b11 (other) and any request whose computed window is zero (size 0) are accepted without opening a window, so back-to-back requests of this kind are all accepted.
- R5: A request presented while the window is open is refused (req_accept low) and marks a retry as owed.
- R6: If a retry is owed when the window closes, retry is high for exactly the one following cycle. Requests are refused during that cycle and accepted from the next cycle on.
- R7: A refused request has no effect: it changes no stored word and produces no reply.
- R8: An accepted request with command 2'b00 (read), 2'b01 (write) or 2'b11 (other) yields one reply exactly LATENCY cycles after its accepting clock edge. The reply is valid for one cycle, replies come in acceptance order, rsp_kind echoes the command, and rsp_data is zero for every kind except a read. Command 2'b10 (posted write) yields no reply.
- R9: A read reply carries the word most recently written to its address (word index req_addr) by a write or posted write. The store resets to zero.
- R10: A window in which no request arrived ends without a retry strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_cmd | input | 2 | 00 read, 01 write, 10 posted write, 11 other |
| req_size | input | SIZE_W | Payload size in bytes |
| req_addr | input | ADDR_W | Word index into the store |
| req_wdata | input | DATA_W | Write data |
| req_accept | output | 1 | Request taken this cycle (low means refused) |
| retry | output | 1 | One-cycle strobe: resend the refused request |
| rsp_valid | output | 1 | Reply valid this cycle |
| rsp_kind | output | 2 | Command of the request being answered |
| rsp_data | output | DATA_W | Read data, zero for other kinds |

## Verification
The sharpest case is a window expiring in the same cycle in which a new request is refused. The machine must then go straight from BUSY to RETRY rather than back to IDLE. The bench provokes this by presenting requests on every cycle across the last cycles of a window. A behavioural model, built from counters and queues, predicts each cycle's accept, strobe and reply values, and these are compared with the outputs at every falling edge. A second overlap, a reply leaving the queue while another is pushed, is exercised by back-to-back "other" commands.

// File: rtl/bwmem_pkg.sv
package bwmem_pkg;

    typedef enum logic [1:0] {
        CMD_READ  = 2'b00,
        CMD_WRITE = 2'b01,
        CMD_POST  = 2'b10,
        CMD_OTHER = 2'b11
    } cmd_e;

    typedef enum logic [1:0] {
        TH_IDLE      = 2'b00,
        TH_BUSY      = 2'b01,
        TH_BUSY_OWED = 2'b10,
        TH_RETRY     = 2'b11
    } th_state_e;

endpackage

// File: rtl/bwmem_throttle.sv
module bwmem_throttle
    import bwmem_pkg::*;
#(
    parameter int SIZE_W  = 7,
    parameter int CPB_NUM = 1,
    parameter int CPB_DEN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_is_rw,
    input  logic [SIZE_W-1:0] req_size,
    output logic              accept_o,
    output logic              retry_o,
    output logic              idle_o
);

    localparam int MAX_SIZE = (1 << SIZE_W) - 1;
    localparam int MAX_DUR  = (MAX_SIZE * CPB_NUM + CPB_DEN - 1) / CPB_DEN;
    localparam int CNT_W    = (MAX_DUR < 2) ? 1 : $clog2(MAX_DUR + 1);

    th_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] dur;
    logic             last_cycle;
    logic             start;

    // Window length in whole cycles, rounded up.
    always_comb begin
        int full;
        full = (int'(req_size) * CPB_NUM + CPB_DEN - 1) / CPB_DEN;
        dur  = CNT_W'(full);
    end

    assign last_cycle = (cnt_q == CNT_W'(1));
    assign start      = req_valid && req_is_rw && (dur != '0);

    // Next state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TH_IDLE:      if (start) state_d = TH_BUSY;
            TH_BUSY: begin
                if (last_cycle)     state_d = req_valid ? TH_RETRY : TH_IDLE;
                else if (req_valid) state_d = TH_BUSY_OWED;
            end
            TH_BUSY_OWED: if (last_cycle) state_d = TH_RETRY;
            TH_RETRY:     state_d = TH_IDLE;
            default:      state_d = TH_IDLE;
        endcase
    end

    // Window counter.
    always_comb begin
        cnt_d = '0;
        unique case (state_q)
            TH_IDLE:                cnt_d = start ? dur : '0;
            TH_BUSY, TH_BUSY_OWED:  cnt_d = cnt_q - CNT_W'(1);
            default:                cnt_d = '0;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TH_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Outputs.
    always_comb begin
        idle_o   = 1'b0;
        retry_o  = 1'b0;
        unique case (state_q)
            TH_IDLE:  idle_o  = 1'b1;
            TH_RETRY: retry_o = 1'b1;
            default: ;
        endcase
        accept_o = req_valid && idle_o;
    end

    assert_window_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_o && req_is_rw && dur != '0) |=> !idle_o);

    assert_count_live_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TH_BUSY || state_q == TH_BUSY_OWED) |-> cnt_q != '0);

    assert_other_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_o && !req_is_rw) |=> idle_o);

    assert_retry_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        retry_o |=> (!retry_o && idle_o));

    assert_refuse_owes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !accept_o && !retry_o && last_cycle) |=> retry_o);

endmodule

// File: rtl/bwmem_store.sv
module bwmem_store #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int WORDS = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
        end else if (wr_en) begin
            mem_q[addr] <= wdata;
        end
    end

    assign rdata = mem_q[addr];

endmodule

// File: rtl/bwmem_rspq.sv
module bwmem_rspq #(
    parameter int DATA_W  = 32,
    parameter int LATENCY = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [1:0]        push_kind,
    input  logic [DATA_W-1:0] push_data,
    output logic              rsp_valid,
    output logic [1:0]        rsp_kind,
    output logic [DATA_W-1:0] rsp_data
);

    localparam int QDEPTH = (LATENCY < 1) ? 1 : LATENCY;
    localparam int PTR_W  = (QDEPTH < 2) ? 1 : $clog2(QDEPTH);
    localparam int CNT_W  = $clog2(QDEPTH + 1);
    localparam int TS_W   = $clog2(LATENCY + 1) + 1;

    logic [TS_W-1:0]   now_q;
    logic [TS_W-1:0]   ts_q   [QDEPTH];
    logic [1:0]        kind_q [QDEPTH];
    logic [DATA_W-1:0] data_q [QDEPTH];
    logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0]  count_q;
    logic              head_due;
    logic              pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(QDEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign head_due = (count_q != '0) && (ts_q[rd_ptr_q] == now_q);
    assign pop      = head_due;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            now_q    <= '0;
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
            for (int i = 0; i < QDEPTH; i++) begin
                ts_q[i]   <= '0;
                kind_q[i] <= '0;
                data_q[i] <= '0;
            end
        end else begin
            now_q <= now_q + TS_W'(1);
            if (push) begin
                ts_q[wr_ptr_q]   <= now_q + TS_W'(LATENCY);
                kind_q[wr_ptr_q] <= push_kind;
                data_q[wr_ptr_q] <= push_data;
                wr_ptr_q         <= bump(wr_ptr_q);
            end
            if (pop) rd_ptr_q <= bump(rd_ptr_q);
            count_q <= count_q + CNT_W'(push) - CNT_W'(pop);
        end
    end

    assign rsp_valid = head_due;
    assign rsp_kind  = head_due ? kind_q[rd_ptr_q] : 2'b00;
    assign rsp_data  = head_due ? data_q[rd_ptr_q] : '0;

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> count_q < CNT_W'(QDEPTH));

    assert_head_on_time_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q != '0) |-> TS_W'(ts_q[rd_ptr_q] - now_q) <= TS_W'(LATENCY));

    assert_single_beat_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid || $past(count_q) > CNT_W'(1)));

endmodule

// File: rtl/bwmem_target.sv
module bwmem_target
    import bwmem_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 4,
    parameter int SIZE_W  = 7,
    parameter int CPB_NUM = 1,
    parameter int CPB_DEN = 8,
    parameter int LATENCY = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_cmd,
    input  logic [SIZE_W-1:0] req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_accept,
    output logic              retry,
    output logic              rsp_valid,
    output logic [1:0]        rsp_kind,
    output logic [DATA_W-1:0] rsp_data
);

    cmd_e              cmd;
    logic              is_rw;
    logic              is_wr;
    logic              wants_rsp;
    logic              idle;
    logic [DATA_W-1:0] rdata;

    assign cmd       = cmd_e'(req_cmd);
    assign is_rw     = (cmd != CMD_OTHER);
    assign is_wr     = (cmd == CMD_WRITE) || (cmd == CMD_POST);
    assign wants_rsp = (cmd != CMD_POST);

    bwmem_throttle #(
        .SIZE_W (SIZE_W),
        .CPB_NUM(CPB_NUM),
        .CPB_DEN(CPB_DEN)
    ) throttle_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_is_rw(is_rw),
        .req_size (req_size),
        .accept_o (req_accept),
        .retry_o  (retry),
        .idle_o   (idle)
    );

    bwmem_store #(
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W)
    ) store_i (
        .clk  (clk),
        .rst_n(rst_n),
        .wr_en(req_accept && is_wr),
        .addr (req_addr),
        .wdata(req_wdata),
        .rdata(rdata)
    );

    bwmem_rspq #(
        .DATA_W (DATA_W),
        .LATENCY(LATENCY)
    ) rspq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (req_accept && wants_rsp),
        .push_kind(req_cmd),
        .push_data((cmd == CMD_READ) ? rdata : '0),
        .rsp_valid(rsp_valid),
        .rsp_kind (rsp_kind),
        .rsp_data (rsp_data)
    );

    assert_refused_when_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !idle) |-> !req_accept);

    assert_no_accept_on_retry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        retry |-> !req_accept);

endmodule

// File: tb/bwmem_target_tb_top.sv
module bwmem_target_tb_top;

    localparam int LAT = 4;
    localparam int NUM = 1;
    localparam int DEN = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_cmd = 2'b00;
    logic [6:0]  req_size = '0;
    logic [3:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_accept, retry, rsp_valid;
    logic [1:0]  rsp_kind;
    logic [31:0] rsp_data;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    running = 1'b0;

    always #5 clk = ~clk;

    bwmem_target dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_accept(req_accept), .retry(retry), .rsp_valid(rsp_valid),
        .rsp_kind(rsp_kind), .rsp_data(rsp_data)
    );

    // Behavioural model: mode 0 open, 1 window, 3 strobe cycle.
    int          m_mode = 0;
    int          m_left = 0;
    bit          m_owed = 1'b0;
    int          m_now  = 0;
    logic [31:0] m_mem [16];
    int          q_due  [$];
    logic [1:0]  q_kind [$];
    logic [31:0] q_data [$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_left = 0; m_owed = 0; m_now = 0;
            for (int i = 0; i < 16; i++) m_mem[i] = '0;
            q_due.delete(); q_kind.delete(); q_data.delete();
        end else begin
            bit   acc;
            int   w;
            logic [31:0] rd;
            acc = req_valid && (m_mode == 0);
            if (q_due.size() > 0 && q_due[0] == m_now) begin
                void'(q_due.pop_front()); void'(q_kind.pop_front()); void'(q_data.pop_front());
            end
            w = (int'(req_size) * NUM + DEN - 1) / DEN;
            if (acc) begin
                rd = m_mem[req_addr];
                if (req_cmd == 2'b01 || req_cmd == 2'b10) m_mem[req_addr] = req_wdata;
                if (req_cmd != 2'b10) begin
                    q_due.push_back(m_now + LAT);
                    q_kind.push_back(req_cmd);
                    q_data.push_back(req_cmd == 2'b00 ? rd : 32'h0);
                end
            end
            if (m_mode == 0) begin
                if (acc && req_cmd != 2'b11 && w > 0) begin m_mode = 1; m_left = w; end
            end else if (m_mode == 1) begin
                if (req_valid) m_owed = 1;
                if (m_left == 1) begin
                    m_mode = m_owed ? 3 : 0;
                    m_left = 0;
                end else m_left--;
            end else begin
                m_mode = 0; m_owed = 0;
            end
            m_now++;
        end
    end

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", cur_req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (running && rst_n) begin
            bit due;
            due = (q_due.size() > 0) && (q_due[0] == m_now);
            chk("accept", 32'(req_accept), 32'(req_valid && m_mode == 0));
            chk("retry", 32'(retry), 32'(m_mode == 3));
            chk("rsp_valid", 32'(rsp_valid), 32'(due));
            if (due) begin
                chk("rsp_kind", 32'(rsp_kind), 32'(q_kind[0]));
                chk("rsp_data", rsp_data, q_data[0]);
            end
        end
    end

    task automatic issue(input logic [1:0] c, input int sz, input int a, input logic [31:0] d);
        @(posedge clk); #2;
        req_valid = 1'b1; req_cmd = c; req_size = 7'(sz); req_addr = 4'(a); req_wdata = d;
    endtask

    task automatic quiet(input int n);
        repeat (n) begin @(posedge clk); #2; req_valid = 1'b0; end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        running = 1'b1;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        cur_req = "R1";  quiet(3);
        issue(2'b11, 0, 0, 0); quiet(6);
        cur_req = "R9";  issue(2'b01, 4, 3, 32'hA5A5_0001); quiet(2);
        issue(2'b00, 4, 3, 0); quiet(6);
        issue(2'b10, 1, 7, 32'h0000_0077); quiet(2);
        issue(2'b00, 1, 7, 0); quiet(6);
        cur_req = "R2";  issue(2'b00, 64, 3, 0); quiet(6);
        for (int i = 0; i < 4; i++) issue(2'b11, 0, 0, 0);
        quiet(6);
        issue(2'b01, 17, 1, 32'h1717); issue(2'b11, 0, 0, 0); issue(2'b11, 0, 0, 0);
        issue(2'b11, 0, 0, 0); issue(2'b11, 0, 0, 0); issue(2'b11, 0, 0, 0); quiet(6);
        cur_req = "R3";  issue(2'b01, 16, 2, 32'h2222); issue(2'b00, 8, 2, 0); quiet(4);
        issue(2'b00, 8, 2, 0); quiet(3);
        issue(2'b00, 16, 9, 0); issue(2'b01, 8, 9, 32'h9999); quiet(4);
        issue(2'b00, 4, 9, 0); quiet(6);
        cur_req = "R4";  issue(2'b11, 64, 0, 0); issue(2'b11, 64, 0, 0); issue(2'b11, 8, 0, 0);
        issue(2'b01, 0, 4, 32'h4444); issue(2'b00, 0, 4, 0); quiet(6);
        cur_req = "R5";  issue(2'b01, 64, 5, 32'h1111);
        for (int i = 0; i < 3; i++) issue(2'b01, 4, 5, 32'h2222);
        quiet(8);
        cur_req = "R6";  issue(2'b00, 16, 6, 0); issue(2'b11, 0, 0, 0);
        issue(2'b11, 0, 0, 0); issue(2'b11, 0, 0, 0); issue(2'b11, 0, 0, 0); quiet(6);
        cur_req = "R7";  issue(2'b00, 4, 5, 0); quiet(6);
        cur_req = "R8";  issue(2'b11, 0, 0, 0); issue(2'b10, 0, 8, 32'h88);
        issue(2'b00, 0, 4, 0); issue(2'b01, 0, 8, 32'h89); issue(2'b00, 0, 8, 0); quiet(8);
        cur_req = "R10"; issue(2'b00, 24, 1, 0); quiet(6);
        finish_run();
    end

endmodule